// File: doc/BRIEF.md
# Parallel ADC Sample Sequencer

This block sits on the host side of a 14-bit successive-approximation converter that has a parallel output bus. It turns one start request into a complete sample by driving three falling edges on the converter's chip-select line. The first edge, with the read/convert line low, begins acquisition. The second edge ends acquisition and starts conversion; the level of the read/convert line at that edge picks the power state the converter enters afterwards. The controller then waits for end-of-conversion to go low. The third edge, with the read/convert line high, places the result on the bus. The word is taken either from a full-width bus or, in byte mode, as a low and a high byte chosen by a byte-select output.

Every interval is a clock-cycle count parameter: chip-select low and high widths, acquisition length, reference wake-up time, bus-valid delay after the read edge, delay after a byte-select toggle, bus relinquish gap, and end-of-conversion timeout. After reset, after any sample taken in shutdown mode, and after a timeout, the next request first stretches acquisition to the wake-up time. It then runs one throwaway conversion in standby before the real one. The result is presented with a one-cycle strobe.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, chip-select is high, read/convert and byte-select are low, and busy, valid and error are all low.
- R2: A start pulse seen while idle raises busy on the next cycle; start pulses that arrive while busy are ignored, so one start yields exactly one valid strobe.
- R3: Each conversion uses an acquire fall with read/convert low, then a convert fall, then a read fall with read/convert high; read/convert never changes while chip-select is low or on the edge where it falls.
- R4: Every chip-select low pulse lasts at least CS_LO_CYC cycles and every high interval at least CS_HI_CYC cycles. The span from the acquire fall to the convert fall is at least ACQ_CYC cycles.
- R5: For a real sample, read/convert at the convert fall equals shdn_i as sampled with the accepted start: 1 selects shutdown, 0 selects standby.
- R6: If the reference may be off (after reset, after a shutdown-mode sample, or after a timeout), a start produces two conversions and two reads. The first has an acquire span of at least WAKE_CYC cycles and read/convert low at its convert fall, and its data is discarded. After a standby-mode sample, a start produces exactly one conversion and one read.
- R7: In byte mode (BYTE_MODE=1, 8-bit bus), the bus is sampled DATA_CYC cycles after the read fall with byte-select low, giving result bits 7:0. Byte-select then goes high while chip-select stays low, and the bus is sampled HBEN_CYC cycles later; bus bits 5:0 give result bits 13:8, and bus bits 7:6 are zero.
- R8: In wide mode (BYTE_MODE=0), the 14-bit bus is sampled once, DATA_CYC cycles after the read fall, and byte-select stays low.
- R9: After chip-select rises from a read, it stays high at least RELQ_CYC cycles before the next fall. The valid strobe lasts one cycle, carries the real sample's word, and busy is low while it is high.
- R10: If end-of-conversion has not gone low EOC_TMO_CYC cycles after the convert pulse, error pulses for one cycle, chip-select returns high, busy drops, no valid strobe is given, and the next start performs the R6 wake-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one sample |
| shdn_i | input | 1 | Power state after conversion: 1 shutdown, 0 standby |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | One-cycle strobe, result_o holds a new sample |
| result_o | output | RES_W | Assembled sample word |
| err_o | output | 1 | One-cycle pulse on end-of-conversion timeout |
| cs_no | output | 1 | Converter chip-select, active low |
| rc_o | output | 1 | Converter read/convert select |
| hben_o | output | 1 | Byte select: 1 high byte, 0 low byte |
| eoc_ni | input | 1 | End of conversion from converter, active low |
| data_i | input | BUS_W | Converter data bus |

## Verification
The assertions check the pin-level timing rules on every cycle: the minimum chip-select low and high widths, that read/convert is steady while chip-select is low, that byte-select is used only during a read, that an idle start raises busy, and that the valid and error pulses both leave the block idle. Other properties span whole samples, and only the bench scenarios against a behavioural converter model can show them. These are the acquisition and wake-up spans, the extra discarded conversion after shutdown or timeout, the power-state level at the convert edge, the correct byte and word assembly when the bus carries junk before its valid delay, the relinquish gap, and that a start issued mid-sample is ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ_LO,
    ST_ACQ_HI,
    ST_CNV_LO,
    ST_CNV_WAIT,
    ST_RD_LO,
    ST_RD_HB,
    ST_RELQ
  } rd_state_e;

  typedef struct packed {
    logic cs_n;
    logic rc;
    logic hben;
  } pins_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  // reset high: end-of-conversion input is active low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int BYTE_MODE = 1,
  parameter int RES_W     = 14,
  parameter int BUS_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_en_i,
  input  logic             hi_en_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [RES_W-1:0] word_o
);

  generate
    if (BYTE_MODE != 0) begin : g_byte
      localparam int HI_W = RES_W - BUS_W;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_o <= '0;
        else begin
          if (lo_en_i) word_o[BUS_W-1:0]     <= bus_i;
          if (hi_en_i) word_o[RES_W-1:BUS_W] <= bus_i[HI_W-1:0];
        end
      end

      // high byte carries zero padding above the result MSB
      assert_hi_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_en_i |-> (bus_i[BUS_W-1:HI_W] == '0));
    end else begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                word_o <= '0;
        else if (lo_en_i | hi_en_i) word_o <= bus_i[RES_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int BYTE_MODE   = 1,
  parameter int BUS_W       = (BYTE_MODE != 0) ? 8 : RES_W,
  parameter int CS_LO_CYC   = 5,
  parameter int CS_HI_CYC   = 5,
  parameter int ACQ_CYC     = 138,
  parameter int WAKE_CYC    = 1250000,
  parameter int DATA_CYC    = 10,
  parameter int HBEN_CYC    = 10,
  parameter int RELQ_CYC    = 10,
  parameter int EOC_TMO_CYC = 650
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             shdn_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic             err_o,
  output logic             cs_no,
  output logic             rc_o,
  output logic             hben_o,
  input  logic             eoc_ni,
  input  logic [BUS_W-1:0] data_i
);

  localparam int MAX_CYC  = max2(max2(WAKE_CYC, EOC_TMO_CYC),
                                 max2(max2(ACQ_CYC, RELQ_CYC), max2(DATA_CYC, HBEN_CYC)));
  localparam int CW       = $clog2(MAX_CYC + 1) + 1;
  localparam int RELQ_LIM = max2(RELQ_CYC, CS_HI_CYC);

  rd_state_e state_q, state_d;
  pins_t     pins_q;
  logic [CW-1:0] cnt, lim;
  logic lim_done, eoc_s, tmo, fin, lo_en, hi_en, conv_rc;
  logic mode_q, dummy_q, waking_q, ref_off_q, valid_q, err_q;

  adc_rd_timer #(.CW(CW)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .cnt_o (cnt)
  );

  adc_rd_sync #(.STAGES(2)) i_eoc_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (eoc_ni),
    .q_o   (eoc_s)
  );

  // the throwaway conversion always keeps the reference on
  assign conv_rc = dummy_q ? 1'b0 : mode_q;

  always_comb begin
    unique case (state_q)
      ST_ACQ_LO, ST_CNV_LO: lim = CW'(CS_LO_CYC);
      ST_ACQ_HI: lim = waking_q ? CW'(WAKE_CYC - CS_LO_CYC) : CW'(ACQ_CYC - CS_LO_CYC);
      ST_RD_LO:  lim = CW'(DATA_CYC);
      ST_RD_HB:  lim = CW'(HBEN_CYC);
      ST_RELQ:   lim = CW'(RELQ_LIM);
      default:   lim = CW'(CS_HI_CYC);
    endcase
  end

  assign lim_done = (cnt == lim - 1'b1);

  always_comb begin
    state_d = state_q;
    tmo     = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start_i)  state_d = ST_ACQ_LO;
      ST_ACQ_LO: if (lim_done) state_d = ST_ACQ_HI;
      ST_ACQ_HI: if (lim_done) state_d = ST_CNV_LO;
      ST_CNV_LO: if (lim_done) state_d = ST_CNV_WAIT;
      ST_CNV_WAIT: begin
        if (!eoc_s && cnt >= CW'(CS_HI_CYC - 1)) state_d = ST_RD_LO;
        else if (cnt >= CW'(EOC_TMO_CYC - 1)) begin
          state_d = ST_IDLE;
          tmo     = 1'b1;
        end
      end
      ST_RD_LO:  if (lim_done) state_d = (BYTE_MODE != 0) ? ST_RD_HB : ST_RELQ;
      ST_RD_HB:  if (lim_done) state_d = ST_RELQ;
      ST_RELQ: if (lim_done) begin
        state_d = dummy_q ? ST_ACQ_LO : ST_IDLE;
        fin     = !dummy_q;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  function automatic pins_t pins_of(rd_state_e s, logic crc);
    unique case (s)
      ST_ACQ_LO:   return '{cs_n: 1'b0, rc: 1'b0, hben: 1'b0};
      ST_ACQ_HI:   return '{cs_n: 1'b1, rc: crc,  hben: 1'b0};
      ST_CNV_LO:   return '{cs_n: 1'b0, rc: crc,  hben: 1'b0};
      ST_CNV_WAIT: return '{cs_n: 1'b1, rc: 1'b1, hben: 1'b0};
      ST_RD_LO:    return '{cs_n: 1'b0, rc: 1'b1, hben: 1'b0};
      ST_RD_HB:    return '{cs_n: 1'b0, rc: 1'b1, hben: 1'b1};
      default:     return '{cs_n: 1'b1, rc: 1'b0, hben: 1'b0};
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pins_q    <= '{cs_n: 1'b1, rc: 1'b0, hben: 1'b0};
      mode_q    <= 1'b0;
      dummy_q   <= 1'b0;
      waking_q  <= 1'b0;
      ref_off_q <= 1'b1;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_of(state_d, conv_rc);
      valid_q <= fin;
      err_q   <= tmo;
      if (state_q == ST_IDLE && start_i) begin
        mode_q   <= shdn_i;
        dummy_q  <= ref_off_q;
        waking_q <= ref_off_q;
      end
      if (state_q == ST_RELQ && lim_done && dummy_q) begin
        dummy_q  <= 1'b0;
        waking_q <= 1'b0;
      end
      if (fin) ref_off_q <= mode_q;
      if (tmo) ref_off_q <= 1'b1;
    end
  end

  assign lo_en = (state_q == ST_RD_LO) && lim_done && !dummy_q;
  assign hi_en = (state_q == ST_RD_HB) && lim_done && !dummy_q;

  adc_rd_capture #(.BYTE_MODE(BYTE_MODE), .RES_W(RES_W), .BUS_W(BUS_W)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lo_en_i(lo_en),
    .hi_en_i(hi_en),
    .bus_i  (data_i),
    .word_o (result_o)
  );

  assign cs_no   = pins_q.cs_n;
  assign rc_o    = pins_q.rc;
  assign hben_o  = pins_q.hben;
  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // pulse-width monitors for the chip-select checks
  logic [CW-1:0] lo_run, hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= '1;
    end else if (cs_no) begin
      lo_run <= '0;
      if (hi_run != '1) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != '1) lo_run <= lo_run + 1'b1;
    end
  end

  assert_cs_lo_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (lo_run >= CW'(CS_LO_CYC)));
  assert_cs_hi_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_run >= CW'(CS_HI_CYC)));
  assert_rc_steady_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> $stable(rc_o));
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!busy_o && !err_o && !$past(valid_o)));
  assert_tmo_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && cs_no && !$past(err_o)));
  assert_hben_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hben_o |-> (!cs_no && rc_o));

endmodule

// File: tb/test_adc_rd_ctrl.sv
module adc_model #(
  parameter int BYTE_MODE = 1,
  parameter int BUS_W     = 8,
  parameter int DLY       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rc,
  input  logic             hben,
  input  logic             stuck,
  input  int               dly,
  output logic             eoc_n,
  output logic [BUS_W-1:0] data,
  output int               conv_cnt,
  output int               rd_cnt,
  output int               perr,
  output int               min_lo,
  output int               min_hi,
  output int               min_gap,
  output int               acq_last,
  output int               acq_prev,
  output logic             rc_last,
  output logic             rc_prev,
  output logic [13:0]      code
);
  int phase, cyc, lo_t, hi_t, rel_t, acq_t, left, dcnt;
  bit rel_seen;
  logic pcs, phb;
  logic [13:0] w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; cyc = 0; lo_t = 0; hi_t = 0; rel_t = 0; acq_t = 0; left = 0; dcnt = 0;
      rel_seen = 0; pcs = 1; phb = 0;
      conv_cnt = 0; rd_cnt = 0; perr = 0;
      min_lo = 1000000; min_hi = 1000000; min_gap = 1000000;
      acq_last = 0; acq_prev = 0; rc_last = 0; rc_prev = 0; code = '0;
      eoc_n <= 1'b1;
      data  <= '0;
    end else begin
      cyc++;
      if (pcs && !cs_n) begin
        if (cyc - hi_t < min_hi) min_hi = cyc - hi_t;
        lo_t = cyc;
        if (phase == 1) begin
          acq_prev = acq_last; acq_last = cyc - acq_t;
          rc_prev = rc_last; rc_last = rc;
          conv_cnt++;
          code = 14'($urandom);
          left = dly;
          phase = 2;
        end else if (phase == 3 && rc) begin
          rd_cnt++; phase = 4; dcnt = 0;
        end else if ((phase == 0 || phase == 2) && !rc) begin
          if (phase == 0 && rel_seen && cyc - rel_t < min_gap) min_gap = cyc - rel_t;
          phase = 1; acq_t = cyc;
        end else perr++;
      end
      if (!pcs && cs_n) begin
        if (cyc - lo_t < min_lo) min_lo = cyc - lo_t;
        hi_t = cyc;
        if (phase == 4) begin phase = 0; rel_t = cyc; rel_seen = 1; end
      end
      if (phase == 2 && !stuck) begin
        if (left <= 0) phase = 3; else left--;
      end
      if (hben != phb) dcnt = 0; else if (dcnt < 100) dcnt++;
      pcs = cs_n; phb = hben;
      if (BYTE_MODE != 0) w = hben ? {8'h00, code[13:8]} : {6'h00, code[7:0]};
      else                w = code;
      eoc_n <= !(phase == 3 || phase == 4);
      data  <= (phase == 4 && dcnt >= DLY) ? w[BUS_W-1:0] : BUS_W'(14'h2A5A);
    end
  end
endmodule

module test_adc_rd_ctrl;
  localparam int CS_LO = 3, CS_HI = 3, ACQ = 20, WAKE = 300;
  localparam int DATA = 4, HBEN = 5, RELQ = 5, TMO = 80;

  logic clk = 0, rst_n = 0, start = 0, shdn = 0, stuck = 0;
  int   dly = 10;
  always #4 clk = ~clk;

  // byte-mode instance
  logic busy_a, valid_a, err_a, cs_a, rc_a, hb_a, eoc_a;
  logic [13:0] res_a;
  logic [7:0]  bus_a;
  int conv_a, rd_a, perr_a, mlo_a, mhi_a, mgap_a, acql_a, acqp_a;
  logic rcl_a, rcp_a;
  logic [13:0] code_a;

  adc_rd_ctrl #(.BYTE_MODE(1), .CS_LO_CYC(CS_LO), .CS_HI_CYC(CS_HI), .ACQ_CYC(ACQ),
    .WAKE_CYC(WAKE), .DATA_CYC(DATA), .HBEN_CYC(HBEN), .RELQ_CYC(RELQ), .EOC_TMO_CYC(TMO))
  i_adc_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shdn_i(shdn), .busy_o(busy_a),
    .valid_o(valid_a), .result_o(res_a), .err_o(err_a), .cs_no(cs_a), .rc_o(rc_a),
    .hben_o(hb_a), .eoc_ni(eoc_a), .data_i(bus_a));

  adc_model #(.BYTE_MODE(1), .BUS_W(8), .DLY(3)) i_model_a (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_a), .rc(rc_a), .hben(hb_a), .stuck(stuck), .dly(dly),
    .eoc_n(eoc_a), .data(bus_a), .conv_cnt(conv_a), .rd_cnt(rd_a), .perr(perr_a),
    .min_lo(mlo_a), .min_hi(mhi_a), .min_gap(mgap_a), .acq_last(acql_a), .acq_prev(acqp_a),
    .rc_last(rcl_a), .rc_prev(rcp_a), .code(code_a));

  // wide-mode instance
  logic busy_b, valid_b, err_b, cs_b, rc_b, hb_b, eoc_b;
  logic [13:0] res_b, bus_b;
  int conv_b, rd_b, perr_b, mlo_b, mhi_b, mgap_b, acql_b, acqp_b;
  logic rcl_b, rcp_b;
  logic [13:0] code_b;

  adc_rd_ctrl #(.BYTE_MODE(0), .CS_LO_CYC(CS_LO), .CS_HI_CYC(CS_HI), .ACQ_CYC(ACQ),
    .WAKE_CYC(WAKE), .DATA_CYC(DATA), .HBEN_CYC(HBEN), .RELQ_CYC(RELQ), .EOC_TMO_CYC(TMO))
  i_adc_rd_ctrl_wide (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shdn_i(shdn), .busy_o(busy_b),
    .valid_o(valid_b), .result_o(res_b), .err_o(err_b), .cs_no(cs_b), .rc_o(rc_b),
    .hben_o(hb_b), .eoc_ni(eoc_b), .data_i(bus_b));

  adc_model #(.BYTE_MODE(0), .BUS_W(14), .DLY(3)) i_model_b (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_b), .rc(rc_b), .hben(hb_b), .stuck(stuck), .dly(dly),
    .eoc_n(eoc_b), .data(bus_b), .conv_cnt(conv_b), .rd_cnt(rd_b), .perr(perr_b),
    .min_lo(mlo_b), .min_hi(mhi_b), .min_gap(mgap_b), .acq_last(acql_b), .acq_prev(acqp_b),
    .rc_last(rcl_b), .rc_prev(rcp_b), .code(code_b));

  int vcnt_a = 0, ecnt_a = 0, vcnt_b = 0, ecnt_b = 0, hb_seen_b = 0;
  logic [13:0] vres_a, vres_b;
  always @(posedge clk) begin
    if (valid_a) begin vcnt_a <= vcnt_a + 1; vres_a <= res_a; end
    if (err_a)   ecnt_a <= ecnt_a + 1;
    if (valid_b) begin vcnt_b <= vcnt_b + 1; vres_b <= res_b; end
    if (err_b)   ecnt_b <= ecnt_b + 1;
    if (hb_b)    hb_seen_b <= hb_seen_b + 1;
  end

  int checks = 0, errors = 0;
  bit ref_off_exp = 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ops(input bit wake);
    return wake ? 2 : 1;
  endfunction

  task automatic check_one(input string nm, input int dv, input int de, input int dc, input int dr,
                           input logic [13:0] res, input logic [13:0] code, input logic rcl,
                           input logic rcp, input int acql, input int acqp, input logic busy,
                           input bit mode, input bit wake);
    chk(dv == 1, "R9", {nm, " valid strobes"}, dv, 1);
    chk(de == 0, "R10", {nm, " no error"}, de, 0);
    chk(res == code, "R7", {nm, " result word"}, res, code);
    chk(dc == exp_ops(wake), "R6", {nm, " conversions"}, dc, exp_ops(wake));
    chk(dr == exp_ops(wake), "R6", {nm, " reads"}, dr, exp_ops(wake));
    chk(rcl == mode, "R5", {nm, " mode at convert edge"}, rcl, mode);
    chk(acql >= ACQ, "R4", {nm, " acquisition span"}, acql, ACQ);
    chk(!busy, "R9", {nm, " idle after valid"}, busy, 0);
    if (wake) begin
      chk(acqp >= WAKE, "R6", {nm, " wake-up span"}, acqp, WAKE);
      chk(rcp == 1'b0, "R6", {nm, " dummy in standby"}, rcp, 0);
    end
  endtask

  task automatic run_sample(input bit mode, input bit extra_start);
    int va, ea, ca, ra, vb, eb, cb, rb, n;
    bit wake;
    wake = ref_off_exp;
    va = vcnt_a; ea = ecnt_a; ca = conv_a; ra = rd_a;
    vb = vcnt_b; eb = ecnt_b; cb = conv_b; rb = rd_b;
    dly = 5 + int'($urandom_range(40));
    @(negedge clk); shdn = mode; start = 1;
    @(negedge clk); start = 0; shdn = $urandom_range(1);
    chk(busy_a && busy_b, "R2", "busy after start", {busy_a, busy_b}, 3);
    if (extra_start) begin
      repeat (6) @(negedge clk);
      shdn = ~mode; start = 1;
      @(negedge clk); start = 0;
    end
    n = 0;
    while (((vcnt_a == va && ecnt_a == ea) || (vcnt_b == vb && ecnt_b == eb)) && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(n < 5000, "R2", "sample completes", n, 5000);
    check_one("byte", vcnt_a - va, ecnt_a - ea, conv_a - ca, rd_a - ra, vres_a, code_a,
              rcl_a, rcp_a, acql_a, acqp_a, busy_a, mode, wake);
    check_one("wide", vcnt_b - vb, ecnt_b - eb, conv_b - cb, rd_b - rb, vres_b, code_b,
              rcl_b, rcp_b, acql_b, acqp_b, busy_b, mode, wake);
    ref_off_exp = mode;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_timeout();
    int va, ea, vb, eb, n;
    va = vcnt_a; ea = ecnt_a; vb = vcnt_b; eb = ecnt_b;
    stuck = 1;
    @(negedge clk); shdn = 0; start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while ((ecnt_a == ea || ecnt_b == eb) && n < 5000) begin @(negedge clk); n++; end
    chk(ecnt_a - ea == 1, "R10", "byte error pulse", ecnt_a - ea, 1);
    chk(ecnt_b - eb == 1, "R10", "wide error pulse", ecnt_b - eb, 1);
    chk(vcnt_a == va && vcnt_b == vb, "R10", "no valid on timeout", vcnt_a - va, 0);
    @(negedge clk);
    chk(!busy_a && !busy_b && cs_a && cs_b, "R10", "idle with CS high", {busy_a, busy_b}, 0);
    stuck = 0;
    ref_off_exp = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_a && cs_b, "R1", "CS high in reset", {cs_a, cs_b}, 3);
    rst_n = 1;
    @(negedge clk);
    chk(cs_a && !rc_a && !hb_a, "R1", "byte pins idle", {cs_a, rc_a, hb_a}, 4);
    chk(cs_b && !rc_b && !hb_b, "R1", "wide pins idle", {cs_b, rc_b, hb_b}, 4);
    chk(!busy_a && !valid_a && !err_a, "R1", "byte status idle", {busy_a, valid_a, err_a}, 0);
    chk(!busy_b && !valid_b && !err_b, "R1", "wide status idle", {busy_b, valid_b, err_b}, 0);

    run_sample(1'b0, 1'b0); // first after reset: wake-up and dummy (R6)
    run_sample(1'b0, 1'b0); // standby: single conversion
    run_sample(1'b1, 1'b1); // shutdown, start while busy ignored (R2)
    run_sample(1'b0, 1'b0); // wake-up after shutdown
    run_timeout();          // R10
    run_sample(1'b1, 1'b0); // wake-up after timeout
    for (int i = 0; i < 30; i++) run_sample($urandom_range(1), $urandom_range(3) == 0);

    chk(perr_a == 0 && perr_b == 0, "R3", "edge order seen by converter", perr_a + perr_b, 0);
    chk(mlo_a >= CS_LO && mlo_b >= CS_LO, "R4", "min CS low", mlo_a < mlo_b ? mlo_a : mlo_b, CS_LO);
    chk(mhi_a >= CS_HI && mhi_b >= CS_HI, "R4", "min CS high", mhi_a < mhi_b ? mhi_a : mhi_b, CS_HI);
    chk(mgap_a >= RELQ && mgap_b >= RELQ, "R9", "relinquish gap", mgap_a < mgap_b ? mgap_a : mgap_b, RELQ);
    chk(hb_seen_b == 0, "R8", "wide mode byte select low", hb_seen_b, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule